// File: doc/BRIEF.md
# Drum Channel Transfer Controller

This block sequences word transfers between an I/O channel and a rotating, word-addressed drum store. The channel first issues a read or write select. It then sends one 36-bit address word, which names a physical drum, a logical drum within it and a starting word. The controller checks that word and refuses a disabled drum, a logical drum number out of range, or a write to a protected logical drum. It then waits for the drum's angular position to reach the target word and moves one word per word time, in either direction, until the end of the logical drum. At that point it ends the transfer with an end-of-file disconnect.

A free-running word-time counter and a position counter model the rotation. Before a write, the controller zeroes the aligned group of half a sector that holds the start word, one word per clock. After that it seeks the target position. A write word that the channel fails to supply in time raises a sticky I/O check, and the stale buffer contents are stored in its place. The store is a synchronous RAM outside the block, reached through a single port.

Top module: `drum_xfer_ctl`

## Requirements
- R1: After reset the controller is idle. `ch_req_wr`, `ch_rvalid`, `disc`, `sel_stall`, `sel_illegal`, `io_check` and `st_en` are all low.
- R2: A select with `sel_code` 2'b01 starts a read and 2'b10 starts a write. Codes 2'b00 and 2'b11 pulse `sel_illegal` one cycle later and have no other effect. A read or write select that arrives while not idle pulses `sel_stall` one cycle later and leaves the transfer in progress unchanged.
- R3: The first channel word after a select is the address. Bits 31:30 give the physical drum, bits 20:18 the logical drum (1 to LOGICALS), and the low log2(SECT_WORDS*SECTORS) bits the word. The store address is {logical-1, word} and the drum number appears on `st_drum`.
- R4: The controller rejects an address in three cases: `drum_en[drum]` is clear, the logical drum is 0 or above LOGICALS, or the transfer is a write and bit drum*LOGICALS+logical-1 of `wprot` is set. On a rejection it pulses `disc` with `disc_trc` high and `disc_eof` low, and returns to idle. Reads from a protected logical drum proceed.
- R5: Once seeking, the first word moves on the word-time tick at which the rotational position reaches the low log2(SECT_WORDS) bits of the word address. Every later word follows exactly WORD_TIME clocks after the one before.
- R6: A read returns the stored words on `ch_rvalid`/`ch_rdata` one clock after each store read. Addresses ascend and cross sector boundaries without a break.
- R7: A write pulses `ch_req_wr` in the cycle after the address is accepted. It then writes zero to every word of the aligned SECT_WORDS/2-word group that holds the start word before any data word is stored.
- R8: At each write word time the buffered channel word is stored at the current address. `ch_req_wr` pulses afterwards unless that word was the last of the logical drum, so an n-word write issues exactly n requests.
- R9: If no new channel word has arrived since the previous store and `ch_conn` is high, `io_check` is set and the previous word is stored again. `io_check` stays set until reset.
- R10: After the last word of the logical drum the controller waits one more word time. It then pulses `disc` with `disc_eof` high and `disc_trc` low if `ch_conn` is high, or pulses nothing if `ch_conn` is low, and returns to idle in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Select strobe |
| sel_code | input | 2 | Select code: 01 read, 10 write |
| sel_stall | output | 1 | Busy refusal pulse |
| sel_illegal | output | 1 | Illegal select pulse |
| ch_wvalid | input | 1 | Channel word strobe (address or write data) |
| ch_wdata | input | 36 | Channel word |
| ch_conn | input | 1 | Channel still connected |
| ch_req_wr | output | 1 | Request for the next write word |
| ch_rvalid | output | 1 | Read word strobe |
| ch_rdata | output | 36 | Read word |
| disc | output | 1 | Disconnect pulse |
| disc_eof | output | 1 | Disconnect cause: end of logical drum |
| disc_trc | output | 1 | Disconnect cause: address rejected |
| io_check | output | 1 | Sticky missing-write-word indicator |
| drum_en | input | 4 | Physical drum present flags |
| wprot | input | 4*LOGICALS | Write-protect switches, LOGICALS bits per drum |
| st_en | output | 1 | Store access enable |
| st_we | output | 1 | Store write enable |
| st_drum | output | 2 | Physical drum of the access |
| st_addr | output | log2(SECT_WORDS*SECTORS)+3 | Word address within the physical drum |
| st_wdata | output | 36 | Store write data |
| st_rdata | input | 36 | Store read data, valid the clock after a read |

## Verification
The bench builds the controller with SECT_WORDS=8, SECTORS=16 and WORD_TIME=12. This gives a 128-word logical drum, an 8-position revolution and 4-word clear groups. With these values a transfer started a few words before a logical-drum end crosses a sector boundary, reaches the end-of-file stop and finishes its group clear, all in a few hundred clocks. The twelve-clock word time leaves room for the channel to answer each write request, and one request can be withheld on purpose to provoke the I/O check.

// File: rtl/drum_xfer_ctl.sv
module drum_xfer_ctl #(
  parameter int SECT_WORDS = 2048,
  parameter int SECTORS    = 16,
  parameter int LOGICALS   = 6,
  parameter int WORD_TIME  = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_valid,
  input  logic [1:0]            sel_code,
  output logic                  sel_stall,
  output logic                  sel_illegal,
  input  logic                  ch_wvalid,
  input  logic [35:0]           ch_wdata,
  input  logic                  ch_conn,
  output logic                  ch_req_wr,
  output logic                  ch_rvalid,
  output logic [35:0]           ch_rdata,
  output logic                  disc,
  output logic                  disc_eof,
  output logic                  disc_trc,
  output logic                  io_check,
  input  logic [3:0]            drum_en,
  input  logic [4*LOGICALS-1:0] wprot,
  output logic                  st_en,
  output logic                  st_we,
  output logic [1:0]            st_drum,
  output logic [$clog2(SECT_WORDS*SECTORS)+2:0] st_addr,
  output logic [35:0]           st_wdata,
  input  logic [35:0]           st_rdata
);
  localparam int LOG_WORDS = SECT_WORDS * SECTORS;
  localparam int LAW = $clog2(LOG_WORDS);
  localparam int SAW = $clog2(SECT_WORDS);
  localparam int GAW = SAW - 1;
  localparam int TW  = $clog2(WORD_TIME + 1);

  typedef enum logic [2:0] {IDLE, FIRST, FILL, SEEK, DATA, EOD} st_t;
  st_t state;

  logic [TW-1:0]  tcnt;
  logic [SAW-1:0] pos;
  logic [LAW-1:0] da;
  logic [2:0]     lg;
  logic [1:0]     phy;
  logic           op, rd_pend, obuf_v;
  logic [35:0]    obuf;
  logic [GAW-1:0] fcnt;

  wire tick = (tcnt == TW'(WORD_TIME - 1));
  wire [SAW-1:0] pos_nx = pos + 1'b1;
  wire at_target = (pos_nx == da[SAW-1:0]);
  wire xfer = tick && ((state == DATA) || (state == SEEK && at_target));
  wire last = &da;
  wire fill_st = (state == FILL);
  wire [2:0] lg_m1 = lg - 3'd1;

  wire [1:0] a_phy = ch_wdata[31:30];
  wire [2:0] a_lg  = ch_wdata[20:18];
  wire [2:0] a_lgm1 = a_lg - 3'd1;
  wire [LOGICALS-1:0] prot_row = wprot[a_phy*LOGICALS +: LOGICALS];
  wire [LOGICALS-1:0] prot_sh = prot_row >> a_lgm1;
  wire a_bad = !drum_en[a_phy] || (a_lg == 3'd0) || (32'(a_lg) > LOGICALS) ||
               (op && prot_sh[0]);

  assign st_en    = fill_st || xfer;
  assign st_we    = fill_st || (xfer && op);
  assign st_drum  = phy;
  assign st_addr  = fill_st ? {lg_m1, da[LAW-1:GAW], fcnt} : {lg_m1, da};
  assign st_wdata = fill_st ? 36'd0 : obuf;
  assign ch_rvalid = rd_pend;
  assign ch_rdata  = st_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      pos  <= '0;
    end else begin
      tcnt <= tick ? '0 : tcnt + 1'b1;
      if (tick) pos <= pos_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE; da <= '0; lg <= '0; phy <= '0; op <= 1'b0;
      obuf <= '0; obuf_v <= 1'b0; fcnt <= '0; rd_pend <= 1'b0;
      sel_stall <= 1'b0; sel_illegal <= 1'b0; ch_req_wr <= 1'b0;
      disc <= 1'b0; disc_eof <= 1'b0; disc_trc <= 1'b0; io_check <= 1'b0;
    end else begin
      sel_stall <= 1'b0; sel_illegal <= 1'b0; ch_req_wr <= 1'b0;
      disc <= 1'b0; disc_eof <= 1'b0; disc_trc <= 1'b0;
      rd_pend <= xfer && !op;

      if (sel_valid) begin
        if (sel_code != 2'b01 && sel_code != 2'b10) sel_illegal <= 1'b1;
        else if (state != IDLE) sel_stall <= 1'b1;
        else begin
          state <= FIRST;
          op <= (sel_code == 2'b10);
        end
      end

      case (state)
        FIRST: if (ch_wvalid) begin
          phy <= a_phy;
          lg  <= a_lg;
          da  <= ch_wdata[LAW-1:0];
          if (a_bad) begin
            disc <= 1'b1; disc_trc <= 1'b1; state <= IDLE;
          end else begin
            obuf <= '0; obuf_v <= 1'b0; fcnt <= '0;
            if (op) begin
              ch_req_wr <= 1'b1; state <= FILL;
            end else state <= SEEK;
          end
        end
        FILL: begin
          fcnt <= fcnt + 1'b1;
          if (&fcnt) state <= SEEK;
        end
        SEEK, DATA: if (xfer) begin
          state <= last ? EOD : DATA;
          da <= da + 1'b1;
          if (op) begin
            if (obuf_v) obuf_v <= 1'b0;
            else if (ch_conn) io_check <= 1'b1;
            if (!last) ch_req_wr <= 1'b1;
          end
        end
        EOD: if (tick) begin
          if (ch_conn) begin disc <= 1'b1; disc_eof <= 1'b1; end
          state <= IDLE;
        end
        default: ;
      endcase

      if (ch_wvalid && (state == FILL || state == SEEK || state == DATA)) begin
        obuf <= ch_wdata;
        obuf_v <= 1'b1;
      end
    end
  end
endmodule

module drum_xfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       op,
  input logic       sel_valid,
  input logic [1:0] sel_code,
  input logic       sel_stall,
  input logic       disc,
  input logic       disc_eof,
  input logic       disc_trc,
  input logic       io_check,
  input logic       ch_rvalid,
  input logic       ch_req_wr,
  input logic       st_en,
  input logic       st_we
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> (!st_en && !ch_req_wr));
  a_r2_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && (sel_code == 2'b01 || sel_code == 2'b10) && state != 3'd0) |=> sel_stall);
  a_r4_disc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    disc |-> (disc_eof != disc_trc));
  a_r6_read_follows_store: assert property (@(posedge clk) disable iff (!rst_n)
    ch_rvalid |-> $past(st_en && !st_we));
  a_r8_req_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    ch_req_wr |-> op);
  a_r9_ioc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    io_check |=> io_check);
  a_r10_eod_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd5) |-> !st_en);
endmodule

bind drum_xfer_ctl drum_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .op(op),
  .sel_valid(sel_valid), .sel_code(sel_code), .sel_stall(sel_stall),
  .disc(disc), .disc_eof(disc_eof), .disc_trc(disc_trc), .io_check(io_check),
  .ch_rvalid(ch_rvalid), .ch_req_wr(ch_req_wr), .st_en(st_en), .st_we(st_we)
);

// File: tb/drum_xfer_ctl_test.sv
`timescale 1ns/1ps
module drum_xfer_ctl_test;
  localparam int SW = 8, NS = 16, NL = 6, WT = 12;
  localparam int LW = SW * NS;
  localparam int AW = $clog2(LW) + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_valid = 1'b0, ch_wvalid = 1'b0, ch_conn = 1'b1;
  logic [1:0] sel_code = 2'b00;
  logic [35:0] ch_wdata = '0;
  logic [3:0] drum_en = 4'b0011;
  logic [4*NL-1:0] wprot = '0;
  logic sel_stall, sel_illegal, ch_req_wr, ch_rvalid, disc, disc_eof, disc_trc, io_check;
  logic st_en, st_we;
  logic [1:0] st_drum;
  logic [AW-1:0] st_addr;
  logic [35:0] ch_rdata, st_wdata, st_rdata;

  always #2 clk = ~clk;

  drum_xfer_ctl #(.SECT_WORDS(SW), .SECTORS(NS), .LOGICALS(NL), .WORD_TIME(WT)) uut (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_code(sel_code),
    .sel_stall(sel_stall), .sel_illegal(sel_illegal), .ch_wvalid(ch_wvalid),
    .ch_wdata(ch_wdata), .ch_conn(ch_conn), .ch_req_wr(ch_req_wr),
    .ch_rvalid(ch_rvalid), .ch_rdata(ch_rdata), .disc(disc), .disc_eof(disc_eof),
    .disc_trc(disc_trc), .io_check(io_check), .drum_en(drum_en), .wprot(wprot),
    .st_en(st_en), .st_we(st_we), .st_drum(st_drum), .st_addr(st_addr),
    .st_wdata(st_wdata), .st_rdata(st_rdata));

  function automatic logic [35:0] pat(input int idx);
    return 36'((idx + 1) * 40503) ^ 36'hA_0000_0000;
  endfunction
  function automatic logic [35:0] wdat(input int seed, input int k);
    return 36'h3_0000_0000 | 36'(seed * 4096 + k * 111 + 7);
  endfunction
  function automatic int idx_of(input int d, input int lg, input int w);
    return d * 1024 + (lg - 1) * LW + w;
  endfunction

  logic [35:0] mem [0:2047];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) mem[i] <= pat(i);
    end else if (st_en) begin
      if (st_we) mem[{st_drum[0], st_addr}] <= st_wdata;
      else st_rdata <= mem[{st_drum[0], st_addr}];
    end
  end

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [35:0] exp_q[$];
  int xfer_id = 0;
  int mon_id = -1, last_t = 0;
  always @(negedge clk) begin
    if (rst_n && ch_rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected read word", 64'(ch_rdata), 64'd0);
      else begin
        logic [35:0] e;
        e = exp_q.pop_front();
        check(ch_rdata == e, "R6 read word", 64'(ch_rdata), 64'(e));
        if (mon_id == xfer_id)
          check(cyc - last_t == WT, "R5 word spacing", 64'(cyc - last_t), 64'(WT));
        mon_id = xfer_id;
        last_t = cyc;
      end
    end
  end

  task automatic do_sel(input logic [1:0] c, output bit stall, output bit ill);
    @(negedge clk); sel_valid = 1'b1; sel_code = c;
    @(negedge clk); sel_valid = 1'b0;
    stall = sel_stall; ill = sel_illegal;
  endtask

  task automatic xfer(input bit wr, input int d, input int lg, input int w, input int skip,
                      input int seed, input bit extra_sel,
                      output bit gd, output bit ge, output bit gt, output int nreq);
    bit s, il;
    int cd;
    logic [35:0] pend;
    gd = 0; ge = 0; gt = 0; nreq = 0; cd = 0; pend = '0;
    xfer_id++;
    do_sel(wr ? 2'b10 : 2'b01, s, il);
    check(!s && !il, "R2 idle select accepted", {s, il}, 0);
    if (extra_sel) begin
      do_sel(2'b10, s, il);
      check(s && !il, "R2 select while busy stalls", {s, il}, 2'b10);
    end
    @(negedge clk);
    ch_wvalid = 1'b1;
    ch_wdata = {4'b0, 2'(d), 9'b0, 3'(lg), 18'(w)};
    @(negedge clk);
    ch_wvalid = 1'b0;
    for (int i = 0; i < 2600; i++) begin
      if (ch_req_wr) begin
        if (nreq != skip) begin cd = 2; pend = wdat(seed, nreq); end
        nreq++;
      end
      if (disc) begin gd = 1; ge = disc_eof; gt = disc_trc; end
      ch_wvalid = 1'b0;
      if (gd) break;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin ch_wvalid = 1'b1; ch_wdata = pend; end
      end
      @(negedge clk);
    end
    ch_wvalid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit s, il, gd, ge, gt;
    int nr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({ch_req_wr, ch_rvalid, disc, sel_stall, sel_illegal, io_check, st_en} == 0,
          "R1 reset outputs", {ch_req_wr, ch_rvalid, disc, sel_stall, sel_illegal, io_check, st_en}, 0);

    // R2 illegal codes
    do_sel(2'b00, s, il);
    check(il && !s, "R2 code 00 illegal", {s, il}, 2'b01);
    do_sel(2'b11, s, il);
    check(il && !s, "R2 code 11 illegal", {s, il}, 2'b01);

    // R3 R5 R6 R10: read across a sector boundary to end of logical drum, busy select stalled
    for (int w = 117; w < LW; w++) exp_q.push_back(pat(idx_of(0, 1, w)));
    xfer(0, 0, 1, 117, -1, 0, 1, gd, ge, gt, nr);
    check(exp_q.size() == 0, "R6 all read words delivered", exp_q.size(), 0);
    check(gd && ge && !gt, "R10 eof disconnect", {gd, ge, gt}, 3'b110);

    // R4 rejections
    wprot[1*NL + 2] = 1'b1;
    xfer(1, 0, 0, 5, -1, 1, 0, gd, ge, gt, nr);
    check(gd && gt && !ge, "R4 logical 0 rejected", {gd, ge, gt}, 3'b101);
    xfer(0, 0, 7, 5, -1, 1, 0, gd, ge, gt, nr);
    check(gd && gt && !ge, "R4 logical 7 rejected", {gd, ge, gt}, 3'b101);
    xfer(0, 2, 1, 5, -1, 1, 0, gd, ge, gt, nr);
    check(gd && gt && !ge, "R4 disabled drum rejected", {gd, ge, gt}, 3'b101);
    xfer(1, 1, 3, 5, -1, 1, 0, gd, ge, gt, nr);
    check(gd && gt && !ge && nr == 0, "R4 protected write rejected", {gd, ge, gt}, 3'b101);
    check(mem[idx_of(1, 3, 5)] == pat(idx_of(1, 3, 5)), "R4 protected word untouched",
          64'(mem[idx_of(1, 3, 5)]), 64'(pat(idx_of(1, 3, 5))));
    for (int w = 126; w < LW; w++) exp_q.push_back(pat(idx_of(1, 3, w)));
    xfer(0, 1, 3, 126, -1, 1, 0, gd, ge, gt, nr);
    check(exp_q.size() == 0 && gd && ge, "R4 protected read proceeds", {exp_q.size(), gd, ge}, 2'b11);

    // R7 R8 clean write with group clear
    xfer(1, 1, 2, 121, -1, 5, 0, gd, ge, gt, nr);
    check(nr == 7, "R8 request count", nr, 7);
    check(mem[idx_of(1, 2, 120)] == 36'd0, "R7 group word cleared", 64'(mem[idx_of(1, 2, 120)]), 0);
    check(mem[idx_of(1, 2, 119)] == pat(idx_of(1, 2, 119)), "R7 word outside group kept",
          64'(mem[idx_of(1, 2, 119)]), 64'(pat(idx_of(1, 2, 119))));
    for (int k = 0; k < 7; k++)
      check(mem[idx_of(1, 2, 121 + k)] == wdat(5, k), "R8 written word",
            64'(mem[idx_of(1, 2, 121 + k)]), 64'(wdat(5, k)));
    check(!io_check && gd && ge, "R8 clean write no io check", {io_check, gd, ge}, 3'b011);

    // R9 missing word
    xfer(1, 0, 4, 124, 2, 9, 0, gd, ge, gt, nr);
    check(io_check, "R9 io check raised", io_check, 1);
    check(mem[idx_of(0, 4, 126)] == wdat(9, 1), "R9 stale word stored",
          64'(mem[idx_of(0, 4, 126)]), 64'(wdat(9, 1)));
    check(mem[idx_of(0, 4, 127)] == wdat(9, 3), "R9 next word after gap",
          64'(mem[idx_of(0, 4, 127)]), 64'(wdat(9, 3)));
    check(mem[idx_of(0, 4, 125)] == wdat(9, 1), "R8 word before gap",
          64'(mem[idx_of(0, 4, 125)]), 64'(wdat(9, 1)));

    // R10 disconnected channel: no disconnect pulse, idle afterwards; R9 sticky
    ch_conn = 1'b0;
    for (int w = 126; w < LW; w++) exp_q.push_back(pat(idx_of(0, 1, w)));
    xfer(0, 0, 1, 126, -1, 0, 0, gd, ge, gt, nr);
    check(!gd && exp_q.size() == 0, "R10 no disconnect when not connected", {gd, exp_q.size()}, 0);
    check(io_check, "R9 io check sticky", io_check, 1);
    do_sel(2'b01, s, il);
    check(!s && !il, "R10 idle after end", {s, il}, 0);

    // R1 reset clears io check
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!io_check && !st_en && !ch_req_wr, "R1 reset clears state", {io_check, st_en, ch_req_wr}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule